// File: doc/BRIEF.md
# Bridge Control Register File

This block holds the control words of a host bridge: power-on and general configuration, I/O and memory-controller settings, address-map control, GPIO data and direction, the interrupt-controller setup, four mailboxes, the cache and error-capture words and the timing words. The 28 words of 32 bits occupy byte offsets 0x100 to 0x16F of the bridge register window. Software reaches them over a simple word-wide bus: a write strobe with an address and data, and a read port that returns the addressed word in the same cycle. The words other blocks need are exported as plain outputs.

The interrupt-enable word cannot be written directly. Software writes a mask to a set word, which ORs the mask into the enable word, or to a clear word, which removes the masked bits. The enable word and the interrupt status word ignore writes. A write to the general-configuration word that moves bit 2 from 0 to 1 makes the block raise a single-cycle system-reset request to the reset controller.

Top module: `hb_ctl_regs`

## Requirements
- R1: After a synchronous active-low reset the words read 0xC40 at 0x100, 0x1384 at 0x104, 0x2BFF8010 at 0x108, 0x255E0091 at 0x10C, 0x6140 at 0x110, 0x1FF at 0x11C and 0x120, 0x8 at 0x168, 0x10000000 at 0x16C, and zero at every other offset.
- R2: The word index is (address - 0x100) >> 2, so address bits [1:0] are ignored; a write to a plain word stores the data, and the stored word is returned on `bus_rdata` from the cycle after the write edge.
- R3: A write to offset 0x130 stores the data in that word and ORs it into the enable word at 0x138.
- R4: A write to offset 0x134 stores the data in that word and clears in the enable word at 0x138 every bit that is 1 in the data.
- R5: Writes to the enable word (0x138) and to the interrupt status word (0x13C) change nothing; the status word stays zero.
- R6: A write to offset 0x104 whose data has bit 2 set while the stored bit 2 is 0 stores the data and drives `sys_rst_req` high for exactly one cycle, the first cycle in which the new value is readable.
- R7: A write to offset 0x104 that leaves bit 2 at 1 or moves it from 1 to 0 stores the data and leaves `sys_rst_req` low.
- R8: Writes to addresses below 0x100 or at or above 0x170 change no word, and reads there return zero.
- R9: The exported outputs equal the stored words: general configuration 0x104, address map 0x110, map configuration 0x118, GPIO data 0x11C, GPIO enable 0x120, edge select 0x124, steering 0x128, polarity 0x12C, interrupt enable 0x138, memory size 0x16C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W (12) | Byte address inside the bridge window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Addressed word, zero outside the block's range |
| sys_rst_req | output | 1 | One-cycle system-reset request |
| gen_cfg_o | output | 32 | General configuration word |
| pci_map_o | output | 32 | Address-map word |
| pci_map_cfg_o | output | 32 | Map configuration word |
| gpio_data_o | output | 32 | GPIO data word |
| gpio_ie_o | output | 32 | GPIO enable word |
| irq_edge_o | output | 32 | Interrupt edge-select word |
| irq_steer_o | output | 32 | Interrupt steering word |
| irq_pol_o | output | 32 | Interrupt polarity word |
| irq_en_o | output | 32 | Interrupt enable word |
| mem_size_o | output | 32 | Memory size word |

## Verification
Two effects share one clock edge here: storing the new general-configuration value and launching the reset request, and likewise storing a set or clear mask and updating the enable word. The bench provokes the first by writing 0x104 with bit 2 rising after first clearing it, then samples in the cycle after the write edge that the read-back value is the new word and that `sys_rst_req` is high in that same cycle and low in the next. For the second it reads both the mask word and the enable word after one set or clear write and judges each against a mask model kept in the bench.

// File: rtl/hb_ctl_pkg.sv
// Shared constants for the bridge control register file: word indices,
// word kinds and reset values. Assumes 32-bit words.
package hb_ctl_pkg;

    localparam int unsigned HB_DATA_W = 32;
    localparam int unsigned HB_WORDS  = 28;

    // Word indices whose behaviour or export depends on position
    localparam int unsigned IX_PWRON     = 0;
    localparam int unsigned IX_GENCFG    = 1;
    localparam int unsigned IX_IODEV     = 2;
    localparam int unsigned IX_SDRAM     = 3;
    localparam int unsigned IX_PCIMAP    = 4;
    localparam int unsigned IX_MAPCFG    = 6;
    localparam int unsigned IX_GPIO_DAT  = 7;
    localparam int unsigned IX_GPIO_IE   = 8;
    localparam int unsigned IX_IRQ_EDGE  = 9;
    localparam int unsigned IX_IRQ_STEER = 10;
    localparam int unsigned IX_IRQ_POL   = 11;
    localparam int unsigned IX_EN_SET    = 12;
    localparam int unsigned IX_EN_CLR    = 13;
    localparam int unsigned IX_EN        = 14;
    localparam int unsigned IX_IRQ_STAT  = 15;
    localparam int unsigned IX_DQ        = 26;
    localparam int unsigned IX_MEMSZ     = 27;

    // Bit of the general configuration word whose rise requests reset
    localparam int unsigned RST_TRIG_BIT = 2;

    typedef enum logic [1:0] {
        WK_PLAIN  = 2'd0,
        WK_RDONLY = 2'd1,
        WK_ENABLE = 2'd2
    } word_kind_e;

    // Value loaded into a word by reset
    function automatic logic [HB_DATA_W-1:0] reset_word(input int unsigned ix);
        case (ix)
            IX_PWRON:    return 32'h0000_0C40;
            IX_GENCFG:   return 32'h0000_1384;
            IX_IODEV:    return 32'h2BFF_8010;
            IX_SDRAM:    return 32'h255E_0091;
            IX_PCIMAP:   return 32'h0000_6140;
            IX_GPIO_DAT: return 32'h0000_01FF;
            IX_GPIO_IE:  return 32'h0000_01FF;
            IX_DQ:       return 32'h0000_0008;
            IX_MEMSZ:    return 32'h1000_0000;
            default:     return '0;
        endcase
    endfunction

    // Storage behaviour of a word
    function automatic word_kind_e kind_of(input int unsigned ix);
        if (ix == IX_EN)       return WK_ENABLE;
        if (ix == IX_IRQ_STAT) return WK_RDONLY;
        return WK_PLAIN;
    endfunction

endpackage

// File: rtl/hb_ctl_decode.sv
// Address decoder: turns a byte address inside the bridge window into a
// range hit, a word index and a one-hot write strobe per word.
// Assumes BASE is word aligned and the index fits below ADDR_W.
module hb_ctl_decode #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BASE   = 32'h100,
    parameter int unsigned WORDS  = 28,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic [WORDS-1:0]  wr_hot
);
    localparam logic [ADDR_W:0]  BASE_A  = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0]  LIMIT_A = (ADDR_W+1)'(BASE + WORDS*4);
    localparam logic [IDX_W-1:0] BASE_W  = IDX_W'(BASE >> 2);

    // Range check over the full address and word index from the low bits
    always_comb begin
        hit = ({1'b0, bus_addr} >= BASE_A) && ({1'b0, bus_addr} < LIMIT_A);
        idx = bus_addr[IDX_W+1:2] - BASE_W;
    end

    // One write strobe per word
    for (genvar g = 0; g < WORDS; g++) begin : g_hot
        assign wr_hot[g] = bus_wr && hit && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/hb_ctl_store.sv
// Word storage: one register per word, built per kind. Plain words take
// the written data, the enable word follows the set and clear words, and
// read-only words hold their reset value. Assumes at most one strobe set.
module hb_ctl_store
    import hb_ctl_pkg::*;
#(
    parameter int unsigned WORDS  = HB_WORDS,
    parameter int unsigned DATA_W = HB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORDS-1:0]  wr_hot,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] words [WORDS]
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam word_kind_e            KIND = kind_of(g);
        localparam logic [DATA_W-1:0]     RVAL = DATA_W'(reset_word(g));
        logic [DATA_W-1:0] q;

        if (KIND == WK_ENABLE) begin : g_en
            // Enable word: OR in set masks, remove clear masks
            always_ff @(posedge clk) begin
                if (!rst_n)                 q <= RVAL;
                else if (wr_hot[IX_EN_SET]) q <= q | wr_data;
                else if (wr_hot[IX_EN_CLR]) q <= q & ~wr_data;
            end
        end else if (KIND == WK_RDONLY) begin : g_ro
            // Read-only word: only reset loads it
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RVAL;
            end
        end else begin : g_plain
            // Plain word: store written data
            always_ff @(posedge clk) begin
                if (!rst_n)         q <= RVAL;
                else if (wr_hot[g]) q <= wr_data;
            end
        end

        assign words[g] = q;
    end
endmodule

// File: rtl/hb_ctl_rstpulse.sv
// Reset-request generator: raises a one-cycle request when a write to the
// general configuration word moves the trigger bit from 0 to 1. The pulse
// is registered so it lines up with the cycle the new value is visible.
module hb_ctl_rstpulse (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cur_bit,
    input  logic new_bit,
    output logic req
);
    // Detect the rising write of the trigger bit
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= cfg_wr && !cur_bit && new_bit;
    end
endmodule

// File: rtl/hb_ctl_regs.sv
// Bridge control register file top: decoder, word storage, reset-request
// generator, read multiplexer and word exports. Reads are combinational;
// writes take effect at the clock edge that samples bus_wr.
module hb_ctl_regs
    import hb_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BASE   = 32'h100,
    parameter int unsigned DATA_W = HB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_rst_req,
    output logic [DATA_W-1:0] gen_cfg_o,
    output logic [DATA_W-1:0] pci_map_o,
    output logic [DATA_W-1:0] pci_map_cfg_o,
    output logic [DATA_W-1:0] gpio_data_o,
    output logic [DATA_W-1:0] gpio_ie_o,
    output logic [DATA_W-1:0] irq_edge_o,
    output logic [DATA_W-1:0] irq_steer_o,
    output logic [DATA_W-1:0] irq_pol_o,
    output logic [DATA_W-1:0] irq_en_o,
    output logic [DATA_W-1:0] mem_size_o
);
    localparam int unsigned WORDS = HB_WORDS;
    localparam int unsigned IDX_W = $clog2(WORDS);

    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [WORDS-1:0]  wr_hot;
    logic [DATA_W-1:0] words [WORDS];

    hb_ctl_decode #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE),
        .WORDS  (WORDS)
    ) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .hit      (hit),
        .idx      (idx),
        .wr_hot   (wr_hot)
    );

    hb_ctl_store #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hot  (wr_hot),
        .wr_data (bus_wdata),
        .words   (words)
    );

    hb_ctl_rstpulse u_rstp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (wr_hot[IX_GENCFG]),
        .cur_bit (words[IX_GENCFG][RST_TRIG_BIT]),
        .new_bit (bus_wdata[RST_TRIG_BIT]),
        .req     (sys_rst_req)
    );

    // Read multiplexer, zero outside the block's range
    always_comb begin
        bus_rdata = '0;
        if (hit) bus_rdata = words[idx];
    end

    // Word exports for neighbouring blocks
    assign gen_cfg_o     = words[IX_GENCFG];
    assign pci_map_o     = words[IX_PCIMAP];
    assign pci_map_cfg_o = words[IX_MAPCFG];
    assign gpio_data_o   = words[IX_GPIO_DAT];
    assign gpio_ie_o     = words[IX_GPIO_IE];
    assign irq_edge_o    = words[IX_IRQ_EDGE];
    assign irq_steer_o   = words[IX_IRQ_STEER];
    assign irq_pol_o     = words[IX_IRQ_POL];
    assign irq_en_o      = words[IX_EN];
    assign mem_size_o    = words[IX_MEMSZ];
endmodule

// File: rtl/hb_ctl_regs_chk.sv
// Property checker for the bridge control register file, bound to the top.
// Observes only ports; addresses are rebuilt from the word indices.
module hb_ctl_regs_chk
    import hb_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BASE   = 32'h100,
    parameter int unsigned DATA_W = HB_DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              sys_rst_req,
    input logic [DATA_W-1:0] gen_cfg_o,
    input logic [DATA_W-1:0] irq_en_o
);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(BASE + IX_EN_SET*4);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(BASE + IX_EN_CLR*4);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(BASE + IX_EN*4);
    localparam logic [ADDR_W:0]   LO_A   = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0]   HI_A   = (ADDR_W+1)'(BASE + HB_WORDS*4);

    logic at_set, at_clr, at_en, outside;
    assign at_set  = bus_addr[ADDR_W-1:2] == A_SET[ADDR_W-1:2];
    assign at_clr  = bus_addr[ADDR_W-1:2] == A_CLR[ADDR_W-1:2];
    assign at_en   = bus_addr[ADDR_W-1:2] == A_EN[ADDR_W-1:2];
    assign outside = ({1'b0, bus_addr} < LO_A) || ({1'b0, bus_addr} >= HI_A);

    p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && at_set |=> irq_en_o == ($past(irq_en_o) | $past(bus_wdata)));

    p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && at_clr |=> irq_en_o == ($past(irq_en_o) & ~$past(bus_wdata)));

    p_en_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && at_en |=> $stable(irq_en_o));

    p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    p_req_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> gen_cfg_o[RST_TRIG_BIT] && !$past(gen_cfg_o[RST_TRIG_BIT]));

    p_outside_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && outside |=> $stable(irq_en_o) && $stable(gen_cfg_o));

    p_outside_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        outside |-> bus_rdata == '0);
endmodule

bind hb_ctl_regs hb_ctl_regs_chk #(
    .ADDR_W (ADDR_W),
    .BASE   (BASE),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/hb_ctl_regs_tb.sv
// Bench for the bridge control register file: a vector table walked by one
// loop, then directed tests for reset values, the reset request and exports.
module hb_ctl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_rst_req;
    logic [31:0] gen_cfg_o, pci_map_o, pci_map_cfg_o, gpio_data_o, gpio_ie_o;
    logic [31:0] irq_edge_o, irq_steer_o, irq_pol_o, irq_en_o, mem_size_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hb_ctl_regs u_dut (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .sys_rst_req (sys_rst_req),
        .gen_cfg_o (gen_cfg_o), .pci_map_o (pci_map_o), .pci_map_cfg_o (pci_map_cfg_o),
        .gpio_data_o (gpio_data_o), .gpio_ie_o (gpio_ie_o), .irq_edge_o (irq_edge_o),
        .irq_steer_o (irq_steer_o), .irq_pol_o (irq_pol_o), .irq_en_o (irq_en_o),
        .mem_size_o (mem_size_o)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [11:0] chk;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h130, 32'h0000_00F0, 12'h138, 32'h0000_00F0, 4'd3}, // R3 set
        '{1'b0, 12'h000, 32'h0,         12'h130, 32'h0000_00F0, 4'd3}, // R3 mask stored
        '{1'b1, 12'h130, 32'h0000_0F00, 12'h138, 32'h0000_0FF0, 4'd3}, // R3 OR
        '{1'b1, 12'h134, 32'h0000_0030, 12'h138, 32'h0000_0FC0, 4'd4}, // R4 clear
        '{1'b0, 12'h000, 32'h0,         12'h134, 32'h0000_0030, 4'd4}, // R4 mask stored
        '{1'b1, 12'h138, 32'hFFFF_FFFF, 12'h138, 32'h0000_0FC0, 4'd5}, // R5 enable RO
        '{1'b1, 12'h13C, 32'h1234_5678, 12'h13C, 32'h0000_0000, 4'd5}, // R5 status RO
        '{1'b1, 12'h140, 32'hCAFE_F00D, 12'h140, 32'hCAFE_F00D, 4'd2}, // R2 mailbox
        '{1'b1, 12'h16C, 32'h2000_0000, 12'h16C, 32'h2000_0000, 4'd2}, // R2 last word
        '{1'b1, 12'h147, 32'h1111_2222, 12'h144, 32'h1111_2222, 4'd2}, // R2 low bits
        '{1'b1, 12'h170, 32'hDEAD_BEEF, 12'h170, 32'h0000_0000, 4'd8}, // R8 above
        '{1'b1, 12'h0FC, 32'hDEAD_BEEF, 12'h100, 32'h0000_0C40, 4'd8}, // R8 below
        '{1'b1, 12'h110, 32'hABCD_0000, 12'h110, 32'hABCD_0000, 4'd2}  // R2 map word
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic check_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: reset values
        check_read(12'h100, 32'h0000_0C40, "R1 0x100");
        check_read(12'h104, 32'h0000_1384, "R1 0x104");
        check_read(12'h108, 32'h2BFF_8010, "R1 0x108");
        check_read(12'h10C, 32'h255E_0091, "R1 0x10C");
        check_read(12'h110, 32'h0000_6140, "R1 0x110");
        check_read(12'h11C, 32'h0000_01FF, "R1 0x11C");
        check_read(12'h120, 32'h0000_01FF, "R1 0x120");
        check_read(12'h168, 32'h0000_0008, "R1 0x168");
        check_read(12'h16C, 32'h1000_0000, "R1 0x16C");
        check_read(12'h114, 32'h0000_0000, "R1 0x114");
        check_read(12'h138, 32'h0000_0000, "R1 0x138");
        check("R1 sys_rst_req", {31'b0, sys_rst_req}, 32'h0);

        // Vector table: R2 R3 R4 R5 R8
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) do_write(VECS[i].addr, VECS[i].data);
            check_read(VECS[i].chk, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R7: bit 2 from 1 to 0, no request
        do_write(12'h104, 32'h0000_1380);
        #1;
        check("R7 fall no request", {31'b0, sys_rst_req}, 32'h0);
        check_read(12'h104, 32'h0000_1380, "R7 value stored");

        // R6: bit 2 from 0 to 1, pulse with the new value in the same cycle
        do_write(12'h104, 32'h0000_1384);
        #1;
        check("R6 request raised", {31'b0, sys_rst_req}, 32'h1);
        check_read(12'h104, 32'h0000_1384, "R6 value visible with request");
        @(negedge clk);
        #1;
        check("R6 request one cycle", {31'b0, sys_rst_req}, 32'h0);

        // R7: bit 2 stays 1, no request
        do_write(12'h104, 32'h0000_0004);
        #1;
        check("R7 steady no request", {31'b0, sys_rst_req}, 32'h0);

        // R9: exported words
        do_write(12'h12C, 32'h0000_00A5);
        #1;
        check("R9 irq_en_o", irq_en_o, 32'h0000_0FC0);
        check("R9 gen_cfg_o", gen_cfg_o, 32'h0000_0004);
        check("R9 pci_map_o", pci_map_o, 32'hABCD_0000);
        check("R9 gpio_data_o", gpio_data_o, 32'h0000_01FF);
        check("R9 irq_pol_o", irq_pol_o, 32'h0000_00A5);
        check("R9 mem_size_o", mem_size_o, 32'h2000_0000);

        // R1: reset again returns the defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_read(12'h138, 32'h0000_0000, "R1 enable after reset");
        check_read(12'h140, 32'h0000_0000, "R1 mailbox after reset");
        check_read(12'h16C, 32'h1000_0000, "R1 size after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule